// File: doc/BRIEF.md
# Windowed Receive Address Translator

This block maps the address carried by each request arriving from a remote link partner into the local bus address space. Software programs up to four receive windows, each given as a size and a local offset. The windows are packed back to back in the incoming address space: window 1 starts at zero, and each later window starts where the previous one ends. An incoming address is matched against the running sums of the window sizes, its window base is subtracted, and that window's offset is added. An address past the end of the last window is reported as a miss and yields no translated address.

A second, independent path handles the outgoing direction. It subtracts a programmable transmit base from a local address, so the partner receives an offset from that base. The upper address bits that the partner does not use for translation are cleared. Both paths are registered, with one cycle of latency. All map registers are loaded through one write port with a register select.

Top module: `rxwin_xlat`

## Requirements
- R1: After reset every map register is zero, all output strobes are low, and any received address raises the miss flag because every window is empty.
- R2: A received address below the window 1 size is output as the address plus the window 1 offset.
- R3: For windows 2 to 4, an address at or above the sum of the earlier window sizes and below that sum plus the window's own size is output as the address minus that sum, plus the window's offset.
- R4: An address at or above the sum of all four sizes drives rx_miss_o high, rx_valid_o low and rx_addr_o to zero.
- R5: rx_valid_o or rx_miss_o rises exactly one cycle after rx_valid_i, never both at once, and stays low in cycles that follow a cycle without rx_valid_i. Back-to-back requests give back-to-back results.
- R6: Bits 1:0 of write data are dropped for every map register, so a size, offset or transmit base always acts as a multiple of four.
- R7: A window of size zero matches no address, and addresses fall through to the next window with a nonzero size.
- R8: The transmit output is (tx_addr_i minus transmit base) with bits 31:26 forced to zero, and tx_valid_o follows tx_valid_i by one cycle.
- R9: cfg_sel_i selects the register written when cfg_we_i is high: 0 is the transmit base, 1 to 4 are the sizes of windows 1 to 4, 5 to 8 are the offsets of windows 1 to 4, and values 9 to 15 change nothing.
- R10: Running size sums are kept one bit wider than the address, so windows whose sizes add past 2^32 still cover the top of the address space, while the offset addition wraps modulo 2^32.
- R11: Bits 1:0 of a translated receive address equal bits 1:0 of the received address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Map register write strobe |
| cfg_sel_i | input | 4 | Map register select |
| cfg_data_i | input | 32 | Map register write data |
| rx_valid_i | input | 1 | Received request address valid |
| rx_addr_i | input | 32 | Received request address |
| tx_valid_i | input | 1 | Outgoing local address valid |
| tx_addr_i | input | 32 | Outgoing local address |
| rx_valid_o | output | 1 | Translated receive address valid |
| rx_miss_o | output | 1 | Received address lies beyond all windows |
| rx_addr_o | output | 32 | Translated local address |
| tx_valid_o | output | 1 | Outgoing offset valid |
| tx_addr_o | output | 32 | Outgoing offset from transmit base |

## Verification
The bench walks addresses on both sides of every window edge, where an off-by-one compare would put the first word of a window into its neighbour or turn the last word of window 4 into a miss. A zero-size window sits between two live ones, so a design that matched an empty window would apply the wrong offset. Size writes carry set low bits, catching a design that keeps them and shifts every later boundary by a few bytes. Large sizes whose sum passes 2^32 and an offset that wraps expose sums held at address width, which would report a false miss at the top of the space. The transmit cases include an address below the base and one with high bits set, to catch a missing upper-bit clear.

// File: rtl/rxwin_xlat_pkg.sv
package rxwin_xlat_pkg;

   // register select codes for the map write port
   localparam int unsigned SEL_TXBASE  = 0;
   localparam int unsigned SEL_SIZE0   = 1;

   function automatic int unsigned sel_offset_base(input int unsigned num_win);
      return SEL_SIZE0 + num_win;
   endfunction

   function automatic int unsigned sel_count(input int unsigned num_win);
      return 1 + 2 * num_win;
   endfunction

   typedef enum logic [1:0] {
      RES_IDLE = 2'b00,
      RES_HIT  = 2'b01,
      RES_MISS = 2'b10
   } rx_res_e;

endpackage

// File: rtl/rxwin_xlat_regs.sv
module rxwin_xlat_regs
   import rxwin_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_WIN   = 4,
   parameter int unsigned ALIGN_LSB = 2,
   parameter int unsigned SEL_W     = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [SEL_W-1:0]                 sel_i,
   input  logic [ADDR_W-1:0]                data_i,
   output logic [ADDR_W-1:0]                txbase_o,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   size_o,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   off_o
);

   localparam int unsigned OFF_SEL0 = sel_offset_base(NUM_WIN);
   localparam int unsigned KEEP_W   = ADDR_W - ALIGN_LSB;

   // reserved low bits never stored
   logic [KEEP_W-1:0] wr_word;
   assign wr_word = data_i[ADDR_W-1:ALIGN_LSB];

   logic [KEEP_W-1:0] txbase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txbase_q <= '0;
      end else if (we_i && (32'(sel_i) == SEL_TXBASE)) begin
         txbase_q <= wr_word;
      end
   end

   assign txbase_o = {txbase_q, {ALIGN_LSB{1'b0}}};

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [KEEP_W-1:0] size_q;
      logic [KEEP_W-1:0] off_q;
      logic              size_hit;
      logic              off_hit;

      assign size_hit = we_i && (32'(sel_i) == (SEL_SIZE0 + w));
      assign off_hit  = we_i && (32'(sel_i) == (OFF_SEL0 + w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q <= '0;
            off_q  <= '0;
         end else begin
            if (size_hit) size_q <= wr_word;
            if (off_hit)  off_q  <= wr_word;
         end
      end

      assign size_o[w] = {size_q, {ALIGN_LSB{1'b0}}};
      assign off_o[w]  = {off_q,  {ALIGN_LSB{1'b0}}};
   end

endmodule

// File: rtl/rxwin_xlat_rxpath.sv
module rxwin_xlat_rxpath
   import rxwin_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]   size_i,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]   off_i,
   input  logic                             valid_i,
   input  logic [ADDR_W-1:0]                addr_i,
   output logic                             valid_o,
   output logic                             miss_o,
   output logic [ADDR_W-1:0]                addr_o
);

   localparam int unsigned SUM_W = ADDR_W + 1;
   localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   // running window bounds, one bit wider than the address
   logic [SUM_W-1:0]  bound [0:NUM_WIN];
   logic [NUM_WIN-1:0] in_win;
   logic [SUM_W-1:0]  addr_ext;

   assign addr_ext = {1'b0, addr_i};
   assign bound[0] = '0;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_bound
      assign bound[w+1] = bound[w] + {1'b0, size_i[w]};
      assign in_win[w]  = (addr_ext >= bound[w]) && (addr_ext < bound[w+1]);
   end

   // lowest matching window wins; empty windows never match
   logic [IDX_W-1:0] win_idx;
   logic             any_hit;

   always_comb begin
      win_idx = '0;
      any_hit = 1'b0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (in_win[w]) begin
            win_idx = IDX_W'(w);
            any_hit = 1'b1;
         end
      end
   end

   logic [ADDR_W-1:0] rel_addr;
   logic [ADDR_W-1:0] xlat_addr;

   assign rel_addr  = addr_i - bound[win_idx][ADDR_W-1:0];
   assign xlat_addr = rel_addr + off_i[win_idx];

   rx_res_e           res_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= RES_IDLE;
         addr_q <= '0;
      end else begin
         if (!valid_i) begin
            res_q  <= RES_IDLE;
            addr_q <= '0;
         end else if (any_hit) begin
            res_q  <= RES_HIT;
            addr_q <= xlat_addr;
         end else begin
            res_q  <= RES_MISS;
            addr_q <= '0;
         end
      end
   end

   assign valid_o = (res_q == RES_HIT);
   assign miss_o  = (res_q == RES_MISS);
   assign addr_o  = addr_q;

endmodule

// File: rtl/rxwin_xlat_txpath.sv
module rxwin_xlat_txpath #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned TX_USED_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] diff;
   logic [ADDR_W-1:0] trimmed;

   assign diff = addr_i - base_i;

   if (TX_USED_W < ADDR_W) begin : g_trim
      assign trimmed = {{(ADDR_W - TX_USED_W){1'b0}}, diff[TX_USED_W-1:0]};
   end else begin : g_full
      assign trimmed = diff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
      end else begin
         valid_o <= valid_i;
         addr_o  <= valid_i ? trimmed : '0;
      end
   end

endmodule

// File: rtl/rxwin_xlat.sv
module rxwin_xlat
   import rxwin_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_WIN   = 4,
   parameter int unsigned ALIGN_LSB = 2,
   parameter int unsigned TX_USED_W = 26,
   parameter int unsigned SEL_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [SEL_W-1:0]  cfg_sel_i,
   input  logic [ADDR_W-1:0] cfg_data_i,
   input  logic              rx_valid_i,
   input  logic [ADDR_W-1:0] rx_addr_i,
   input  logic              tx_valid_i,
   input  logic [ADDR_W-1:0] tx_addr_i,
   output logic              rx_valid_o,
   output logic              rx_miss_o,
   output logic [ADDR_W-1:0] rx_addr_o,
   output logic              tx_valid_o,
   output logic [ADDR_W-1:0] tx_addr_o
);

   localparam int unsigned NUM_SEL = sel_count(NUM_WIN);

   if (ADDR_W <= ALIGN_LSB) begin : g_bad_align
      $error("ALIGN_LSB must be below ADDR_W");
   end
   if (NUM_WIN < 1) begin : g_bad_win
      $error("NUM_WIN must be at least one");
   end
   if (TX_USED_W < 1 || TX_USED_W > ADDR_W) begin : g_bad_tx
      $error("TX_USED_W must lie in 1..ADDR_W");
   end
   if ((1 << SEL_W) < NUM_SEL) begin : g_bad_sel
      $error("SEL_W too narrow for the map registers");
   end

   logic [ADDR_W-1:0]              txbase;
   logic [NUM_WIN-1:0][ADDR_W-1:0] sizes;
   logic [NUM_WIN-1:0][ADDR_W-1:0] offs;

   rxwin_xlat_regs #(
      .ADDR_W    (ADDR_W),
      .NUM_WIN   (NUM_WIN),
      .ALIGN_LSB (ALIGN_LSB),
      .SEL_W     (SEL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (cfg_we_i),
      .sel_i    (cfg_sel_i),
      .data_i   (cfg_data_i),
      .txbase_o (txbase),
      .size_o   (sizes),
      .off_o    (offs)
   );

   rxwin_xlat_rxpath #(
      .ADDR_W  (ADDR_W),
      .NUM_WIN (NUM_WIN)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .size_i  (sizes),
      .off_i   (offs),
      .valid_i (rx_valid_i),
      .addr_i  (rx_addr_i),
      .valid_o (rx_valid_o),
      .miss_o  (rx_miss_o),
      .addr_o  (rx_addr_o)
   );

   rxwin_xlat_txpath #(
      .ADDR_W    (ADDR_W),
      .TX_USED_W (TX_USED_W)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_i  (txbase),
      .valid_i (tx_valid_i),
      .addr_i  (tx_addr_i),
      .valid_o (tx_valid_o),
      .addr_o  (tx_addr_o)
   );

endmodule

// File: rtl/rxwin_xlat_chk.sv
module rxwin_xlat_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned TX_USED_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid_i,
   input logic [ADDR_W-1:0] rx_addr_i,
   input logic              tx_valid_i,
   input logic              rx_valid_o,
   input logic              rx_miss_o,
   input logic [ADDR_W-1:0] rx_addr_o,
   input logic              tx_valid_o,
   input logic [ADDR_W-1:0] tx_addr_o
);

   // R5
   rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid_o && rx_miss_o));

   // R5
   rx_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> (rx_valid_o || rx_miss_o));

   // R5
   rx_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o || rx_miss_o) |-> $past(rx_valid_i));

   // R4
   rx_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_miss_o |-> (rx_addr_o == '0));

   // R11
   rx_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> (rx_addr_o[1:0] == $past(rx_addr_i[1:0])));

   // R8
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o == $past(tx_valid_i));

   // R8
   tx_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> ((tx_addr_o >> TX_USED_W) == '0));

endmodule

bind rxwin_xlat rxwin_xlat_chk #(
   .ADDR_W    (ADDR_W),
   .TX_USED_W (TX_USED_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid_i (rx_valid_i),
   .rx_addr_i  (rx_addr_i),
   .tx_valid_i (tx_valid_i),
   .rx_valid_o (rx_valid_o),
   .rx_miss_o  (rx_miss_o),
   .rx_addr_o  (rx_addr_o),
   .tx_valid_o (tx_valid_o),
   .tx_addr_o  (tx_addr_o)
);

// File: tb/rxwin_xlat_bench.sv
`timescale 1ns/1ps
module rxwin_xlat_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [3:0]  cfg_sel_i = '0;
   logic [31:0] cfg_data_i = '0;
   logic        rx_valid_i = 1'b0;
   logic [31:0] rx_addr_i = '0;
   logic        tx_valid_i = 1'b0;
   logic [31:0] tx_addr_i = '0;
   logic        rx_valid_o;
   logic        rx_miss_o;
   logic [31:0] rx_addr_o;
   logic        tx_valid_o;
   logic [31:0] tx_addr_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   rxwin_xlat u_rxwin_xlat (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we_i   (cfg_we_i),
      .cfg_sel_i  (cfg_sel_i),
      .cfg_data_i (cfg_data_i),
      .rx_valid_i (rx_valid_i),
      .rx_addr_i  (rx_addr_i),
      .tx_valid_i (tx_valid_i),
      .tx_addr_i  (tx_addr_i),
      .rx_valid_o (rx_valid_o),
      .rx_miss_o  (rx_miss_o),
      .rx_addr_o  (rx_addr_o),
      .tx_valid_o (tx_valid_o),
      .tx_addr_o  (tx_addr_o)
   );

   // windows: sizes 0x100 (written as 0x103), 0x200, 0, 0x1000
   localparam int NV = 9;
   localparam logic [31:0] V_ADDR [0:NV-1] = '{
      32'h0000_0000, 32'h0000_00FF, 32'h0000_0100, 32'h0000_0101, 32'h0000_02FC,
      32'h0000_0300, 32'h0000_12FF, 32'h0000_1300, 32'hFFFF_FFFF };
   localparam logic V_HIT [0:NV-1] = '{1,1,1,1,1,1,1,0,0};
   localparam logic [31:0] V_EXP [0:NV-1] = '{
      32'h0200_0000, 32'h0200_00FF, 32'h0300_0000, 32'h0300_0001, 32'h0300_01FC,
      32'h0400_0000, 32'h0400_0FFF, 32'h0000_0000, 32'h0000_0000 };
   localparam string V_REQ [0:NV-1] = '{
      "R2", "R2", "R3/R6", "R11", "R3", "R7", "R3", "R4", "R4" };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we_i   = 1'b1;
      cfg_sel_i  = sel;
      cfg_data_i = data;
      @(negedge clk);
      cfg_we_i   = 1'b0;
   endtask

   task automatic rx_one(input logic [31:0] a, input bit hit,
                         input logic [31:0] exp, input string req);
      @(negedge clk);
      rx_valid_i = 1'b1;
      rx_addr_i  = a;
      @(negedge clk);
      rx_valid_i = 1'b0;
      check(rx_valid_o == hit,  {req, " valid"}, 32'(rx_valid_o), 32'(hit));
      check(rx_miss_o  == !hit, {req, " miss"},  32'(rx_miss_o),  32'(!hit));
      check(rx_addr_o  == exp,  {req, " addr"},  rx_addr_o,       exp);
   endtask

   task automatic tx_one(input logic [31:0] a, input logic [31:0] exp);
      @(negedge clk);
      tx_valid_i = 1'b1;
      tx_addr_i  = a;
      @(negedge clk);
      tx_valid_i = 1'b0;
      check(tx_valid_o == 1'b1, "R8 valid", 32'(tx_valid_o), 32'd1);
      check(tx_addr_o  == exp,  "R8 addr",  tx_addr_o,       exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low in reset and after release
      check(!rx_valid_o && !rx_miss_o && !tx_valid_o, "R1 reset outputs",
            {29'd0, rx_valid_o, rx_miss_o, tx_valid_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_one(32'h0000_0000, 1'b0, 32'h0, "R1 empty map");

      wr(4'd1, 32'h0000_0103);   // R6 low bits dropped
      wr(4'd2, 32'h0000_0200);
      wr(4'd3, 32'h0000_0000);
      wr(4'd4, 32'h0000_1000);
      wr(4'd5, 32'h0200_0000);
      wr(4'd6, 32'h0300_0002);   // R6
      wr(4'd7, 32'h0500_0000);
      wr(4'd8, 32'h0400_0000);

      for (int i = 0; i < NV; i++) begin
         rx_one(V_ADDR[i], V_HIT[i], V_EXP[i], V_REQ[i]);
      end

      // R9: unused select codes change nothing
      wr(4'd9,  32'h0000_0004);
      wr(4'd15, 32'hFFFF_FFFC);
      rx_one(32'h0000_0100, 1'b1, 32'h0300_0000, "R9 ignored select");
      rx_one(32'h0000_1300, 1'b0, 32'h0,          "R9 ignored select");

      // R5: back-to-back then idle
      @(negedge clk);
      rx_valid_i = 1'b1; rx_addr_i = 32'h0000_0004;
      @(negedge clk);
      check(rx_valid_o && rx_addr_o == 32'h0200_0004, "R5 first", rx_addr_o, 32'h0200_0004);
      rx_addr_i = 32'h0000_2000;
      @(negedge clk);
      rx_valid_i = 1'b0;
      check(rx_miss_o && !rx_valid_o, "R5 second", {30'd0, rx_valid_o, rx_miss_o}, 32'd1);
      @(negedge clk);
      check(!rx_miss_o && !rx_valid_o, "R5 idle", {30'd0, rx_valid_o, rx_miss_o}, 32'd0);

      // R8: transmit side
      wr(4'd0, 32'h1000_0003);
      tx_one(32'h1234_5678, 32'h0234_5678);
      tx_one(32'hFC00_0010, 32'h0000_0010);
      tx_one(32'h0FFF_FFFC, 32'h03FF_FFFC);
      @(negedge clk);
      check(!tx_valid_o, "R8 idle", 32'(tx_valid_o), 32'd0);

      // R10: sizes sum past 2^32, offset wrap
      wr(4'd1, 32'h8000_0000);
      wr(4'd2, 32'h8000_0000);
      wr(4'd6, 32'h0000_0010);
      rx_one(32'hFFFF_FFF0, 1'b1, 32'h8000_0000, "R10 wide sum");
      wr(4'd5, 32'hFFFF_FF00);
      rx_one(32'h0000_0200, 1'b1, 32'h0000_0100, "R10 wrap");

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      end
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule